// File: doc/BRIEF.md
# PC Card I/O Access Timing Sequencer

This block runs one access at a time to the I/O space of a 16-bit PC Card style asynchronous socket. A host hands it an address, write data, a direction flag and a 32-bit timing word. The block then walks the card-side bus through four phases: address setup, command strobe, address/data hold and, for writes only, a window at the start of the access during which the data bus is not driven. Read data comes back to the host with a one-cycle response pulse.

The timing word holds four 8-bit counts. Setup and strobe counts are value-plus-one. Hold is the raw value. The high-impedance count applies only to writes. The strobe phase also stretches while the card keeps its wait line low. The wait line is synchronized by two flops before the sequencer looks at it.

Host handshake rules: a request moves when `req_valid` and `req_ready` are both high on a clock edge. `req_ready` is low from the cycle after acceptance until the response cycle. The response is a single-cycle `rsp_valid` pulse and cannot be back-pressured, so the host must take it when it appears. A new request may be accepted in the same cycle as the response.

Top module: `pccard_io_seq`

## Requirements
- R1: After a request is accepted, the address is driven with both strobes high for setup+1 cycles. Setup is bits 7:0 of the timing word.
- R2: Next, `card_we_n` (write) or `card_oe_n` (read) goes low for strobe+1 cycles while the other strobe stays high. The strobe count is bits 15:8, and a value of 0 behaves as 1 (2 cycles). The two strobes are never low together.
- R3: If the synchronized wait line is low in the last programmed strobe cycle, the strobe stays low until the synchronized value is high. A release at `card_wait_n` reaches the sequencer two cycles later.
- R4: After the strobe, both strobes stay high for hold cycles while address and write data are unchanged. Hold is bits 23:16, and a value of 0 behaves as 1.
- R5: For writes, `card_doe` is low during the first hiz cycles counted from the first setup cycle, and high for the rest of the access. Hiz is bits 31:24, and 0 means no delay. For reads, `card_doe` stays low and hiz is ignored.
- R6: For reads, `card_din` is captured in the last cycle that `card_oe_n` is low, and is presented on `rsp_rdata` while `rsp_valid` is high.
- R7: `rsp_valid` is high for exactly one cycle, the first cycle after the hold phase. `req_ready` is low in every cycle of the access before that.
- R8: The timing word, address, write data and direction are latched on acceptance. Changes to these inputs during an access have no effect on the access in progress.
- R9: The timing word layout is hiz in bits 31:24, hold in bits 23:16, strobe in bits 15:8 and setup in bits 7:0.
- R10: After reset, `req_ready` is high, both strobes are high, `card_doe` is low and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_timing | input | 32 | Timing word: hiz, hold, strobe, setup |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | DATA_W | Captured read data |
| card_addr | output | ADDR_W | Address to the card |
| card_dout | output | DATA_W | Write data to the card |
| card_doe | output | 1 | Data bus output enable |
| card_din | input | DATA_W | Read data from the card |
| card_we_n | output | 1 | Write strobe, active low |
| card_oe_n | output | 1 | Read strobe, active low |
| card_wait_n | input | 1 | Card wait request, active low |

## Verification
The assertions assume that the host deasserts `req_valid` once its request has been taken, and does not issue a new request in the response cycle. This keeps the address bus stable through the whole busy window. The stimulus drops `req_valid` in the first cycle after acceptance. In that same cycle it scrambles the address, data, direction and timing word, so that latching is exercised without breaking that assumption. The card wait line is changed only on falling clock edges and is released within a bounded number of cycles, so every stretched strobe ends.

// File: rtl/pccard_io_pkg.sv
package pccard_io_pkg;
  localparam int FIELD_W = 8;
  localparam int CFG_W   = 4 * FIELD_W;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2,
    ST_HOLD   = 2'd3
  } seq_state_t;

  // Field order follows the bit layout, most significant first.
  typedef struct packed {
    logic [FIELD_W-1:0] hiz_len;
    logic [FIELD_W-1:0] hold_len;
    logic [FIELD_W-1:0] strobe_len;
    logic [FIELD_W-1:0] setup_len;
  } timing_cfg_t;
endpackage

// File: rtl/pccard_wait_sync.sv
module pccard_wait_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '1;
    else     chain_q <= {chain_q[STAGES-2:0], async_in};
  end

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/pccard_phase_timer.sv
module pccard_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/pccard_io_seq.sv
module pccard_io_seq
  import pccard_io_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CFG_W-1:0]  cfg_timing,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] card_addr,
  output logic [DATA_W-1:0] card_dout,
  output logic              card_doe,
  input  logic [DATA_W-1:0] card_din,
  output logic              card_we_n,
  output logic              card_oe_n,
  input  logic              card_wait_n
);
  localparam logic [FIELD_W-1:0] ONE = FIELD_W'(1);

  seq_state_t         state_q;
  timing_cfg_t        cfg_q;
  timing_cfg_t        cfg_in;
  logic               wr_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  wdata_q;
  logic [DATA_W-1:0]  rdata_q;
  logic               rsp_q;

  logic               accept;
  logic               wait_ok;
  logic               ph_load;
  logic [FIELD_W-1:0] ph_val;
  logic               ph_done;
  logic               hiz_load;
  logic [FIELD_W-1:0] hiz_val;
  logic               hiz_done;
  logic               strobe_end;
  logic [FIELD_W-1:0] strobe_eff;
  logic [FIELD_W-1:0] hold_last;

  assign cfg_in     = timing_cfg_t'(cfg_timing);
  assign accept     = req_valid && (state_q == ST_IDLE);
  assign strobe_end = (state_q == ST_STROBE) && ph_done && wait_ok;
  // Reserved zero values are promoted to one.
  assign strobe_eff = (cfg_q.strobe_len == '0) ? ONE : cfg_q.strobe_len;
  assign hold_last  = (cfg_q.hold_len == '0) ? '0 : cfg_q.hold_len - ONE;

  pccard_wait_sync #(.STAGES(2)) u_wait_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (card_wait_n),
    .sync_out (wait_ok)
  );

  // Phase length loader: counter holds cycles remaining minus one.
  always_comb begin
    ph_load = 1'b0;
    ph_val  = '0;
    unique case (state_q)
      ST_IDLE: begin
        ph_load = accept;
        ph_val  = cfg_in.setup_len;
      end
      ST_SETUP: begin
        ph_load = ph_done;
        ph_val  = strobe_eff;
      end
      ST_STROBE: begin
        ph_load = strobe_end;
        ph_val  = hold_last;
      end
      default: begin
        ph_load = 1'b0;
        ph_val  = '0;
      end
    endcase
  end

  pccard_phase_timer #(.CNT_W(FIELD_W)) u_phase_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (ph_load),
    .load_val (ph_val),
    .expired  (ph_done)
  );

  assign hiz_load = accept;
  assign hiz_val  = req_write ? cfg_in.hiz_len : '0;

  pccard_phase_timer #(.CNT_W(FIELD_W)) u_hiz_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (hiz_load),
    .load_val (hiz_val),
    .expired  (hiz_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cfg_q   <= '0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      rsp_q   <= 1'b0;
    end else begin
      rsp_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            cfg_q   <= cfg_in;
            wr_q    <= req_write;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            state_q <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (ph_done) state_q <= ST_STROBE;
        end
        ST_STROBE: begin
          if (strobe_end) begin
            if (!wr_q) rdata_q <= card_din;
            state_q <= ST_HOLD;
          end
        end
        default: begin
          if (ph_done) begin
            rsp_q   <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
      endcase
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign rsp_valid = rsp_q;
  assign rsp_rdata = rdata_q;
  assign card_addr = addr_q;
  assign card_dout = wdata_q;
  assign card_we_n = !((state_q == ST_STROBE) && wr_q);
  assign card_oe_n = !((state_q == ST_STROBE) && !wr_q);
  assign card_doe  = (state_q != ST_IDLE) && wr_q && hiz_done;
endmodule

// File: rtl/pccard_io_seq_chk.sv
module pccard_io_seq_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              card_we_n,
  input logic              card_oe_n,
  input logic              card_doe,
  input logic [ADDR_W-1:0] card_addr
);
  assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (rst)
    !(!card_we_n && !card_oe_n));

  assert_ack_after_hold_R4: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(card_we_n && card_oe_n));

  assert_no_drive_on_read_R5: assert property (@(posedge clk) disable iff (rst)
    card_doe |-> card_oe_n);

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  assert_addr_held_R8: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && $past(!req_ready)) |-> $stable(card_addr));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (card_we_n && card_oe_n && !card_doe));
endmodule

bind pccard_io_seq pccard_io_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .card_we_n (card_we_n),
  .card_oe_n (card_oe_n),
  .card_doe  (card_doe),
  .card_addr (card_addr)
);

// File: tb/pccard_io_seq_tb.sv
module pccard_io_seq_tb;
  localparam int AW = 11;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [31:0]   cfg_timing = '0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] card_addr;
  logic [DW-1:0] card_dout;
  logic          card_doe;
  logic [DW-1:0] card_din;
  logic          card_we_n;
  logic          card_oe_n;
  logic          card_wait_n = 1'b1;
  logic [DW-1:0] rd_val = '0;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  // Card model: valid data only while the read strobe is low.
  assign card_din = !card_oe_n ? rd_val : 16'h0BAD;

  pccard_io_seq #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .cfg_timing(cfg_timing),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .card_addr(card_addr), .card_dout(card_dout), .card_doe(card_doe),
    .card_din(card_din), .card_we_n(card_we_n), .card_oe_n(card_oe_n),
    .card_wait_n(card_wait_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_cfg(input int z, input int h, input int w, input int s);
    return {z[7:0], h[7:0], w[7:0], s[7:0]};  // R9 layout
  endfunction

  // One access; release_k = 0 leaves wait high, else wait is low until cycle release_k.
  task automatic run_access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input int z, input int h, input int w, input int s,
                            input int release_k, input logic [DW-1:0] rv);
    int k = 0, n_setup = 0, n_strobe = 0, n_hold = 0, n_hiz = 0;
    int bus_err = 0, rdy_err = 0, other_err = 0, doe_err = 0;
    int weff, heff, exp_strobe, exp_total, exp_hiz;
    bit seen = 0, got = 0;
    logic [DW-1:0] got_data = '0;
    weff = (w == 0) ? 1 : w;
    heff = (h == 0) ? 1 : h;
    exp_strobe = weff + 1;
    if (release_k != 0 && release_k - s + 1 > exp_strobe) exp_strobe = release_k - s + 1;
    @(negedge clk);
    rd_val      = rv;
    card_wait_n = (release_k == 0);
    cfg_timing  = mk_cfg(z, h, w, s);
    req_write   = wr;
    req_addr    = a;
    req_wdata   = d;
    req_valid   = 1'b1;
    while (!got && k < 3000) begin
      @(negedge clk);
      k++;
      if (k == 1) begin
        req_valid  = 1'b0;           // R8: scramble inputs during the access
        req_addr   = ~a;
        req_wdata  = ~d;
        req_write  = ~wr;
        cfg_timing = 32'h0101_0101;
      end
      if (rsp_valid) begin
        got = 1;
        got_data = rsp_rdata;
      end else begin
        bit lo = wr ? !card_we_n : !card_oe_n;
        bit oth = wr ? !card_oe_n : !card_we_n;
        if (req_ready) rdy_err++;
        if (card_addr != a || (wr && card_dout != d)) bus_err++;
        if (oth) other_err++;
        if (!wr && card_doe) doe_err++;
        if (wr && !card_doe) n_hiz++;
        if (lo) begin n_strobe++; seen = 1; end
        else if (!seen) n_setup++;
        else n_hold++;
      end
      if (k == release_k) card_wait_n = 1'b1;
    end
    card_wait_n = 1'b1;
    exp_total = (s + 1) + exp_strobe + heff + 1;
    exp_hiz   = wr ? ((z < exp_total - 1) ? z : exp_total - 1) : 0;
    chk(n_setup == s + 1, "R1 setup cycles", n_setup, s + 1);
    chk(n_strobe == exp_strobe, "R2/R3 strobe cycles", n_strobe, exp_strobe);
    chk(other_err == 0, "R2 opposite strobe low", other_err, 0);
    chk(n_hold == heff, "R4 hold cycles", n_hold, heff);
    chk(bus_err == 0, "R4/R8 address or data changed", bus_err, 0);
    chk(n_hiz == exp_hiz, "R5 hiz cycles", n_hiz, exp_hiz);
    chk(doe_err == 0, "R5 bus driven on read", doe_err, 0);
    chk(k == exp_total, "R7 response cycle", k, exp_total);
    chk(rdy_err == 0, "R7 ready during access", rdy_err, 0);
    if (!wr) chk(got_data == rv, "R6 read data", int'(got_data), int'(rv));
    @(negedge clk);
    chk(!rsp_valid, "R7 response width", int'(rsp_valid), 0);
  endtask

  task automatic t_reset;
    chk(req_ready, "R10 ready", int'(req_ready), 1);
    chk(card_we_n && card_oe_n, "R10 strobes", int'({card_we_n, card_oe_n}), 3);
    chk(!card_doe, "R10 doe", int'(card_doe), 0);
    chk(!rsp_valid, "R10 rsp", int'(rsp_valid), 0);
  endtask

  task automatic t_write_basic;   run_access(1, 11'h123, 16'hBEEF, 4, 2, 3, 2, 0, 16'h0000); endtask
  task automatic t_read_basic;    run_access(0, 11'h045, 16'h0000, 9, 1, 1, 0, 0, 16'hA5C3); endtask
  task automatic t_reserved_vals; run_access(0, 11'h7FF, 16'h0000, 0, 0, 0, 1, 0, 16'h1234); endtask
  task automatic t_wait_stretch;  run_access(0, 11'h200, 16'h0000, 0, 3, 2, 1, 12, 16'h5A5A); endtask
  task automatic t_wait_early;    run_access(1, 11'h0F0, 16'h4321, 2, 1, 4, 3, 2, 16'h0000); endtask
  task automatic t_long_write;    run_access(1, 11'h3C3, 16'hC001, 100, 20, 30, 40, 0, 16'h0000); endtask
  task automatic t_hiz_zero;      run_access(1, 11'h001, 16'h8001, 0, 5, 1, 0, 0, 16'h0000); endtask
  task automatic t_max_fields;    run_access(0, 11'h555, 16'h0000, 255, 255, 255, 255, 0, 16'hFACE); endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_write_basic();
    t_read_basic();
    t_reserved_vals();
    t_wait_stretch();
    t_wait_early();
    t_long_write();
    t_hiz_zero();
    t_max_fields();
    t_read_basic();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL R7 watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule